// File: doc/BRIEF.md
# Speculative Commit and Result Tracker

This block sits on the coprocessor side of an instruction offload link. It keeps one tracking entry for every possible instruction identifier. An entry is claimed when the CPU offloads an instruction and the coprocessor accepts it. The entry then follows that instruction through two independent events, which may arrive in either order or in the same cycle. The first is the CPU's commit strobe, which either clears the instruction to retire or kills it. The second is the completion report from the execution datapath, which carries the result payload.

A result is offered on a valid/ready channel only once both events have happened and the commit did not kill the instruction. If the completion is already held when a clearing commit strobe arrives, the result is offered in that same cycle. A killed entry is released without producing any result. If its completion is still outstanding, the entry waits for that completion and drops it. Commit strobes that refer to instructions the coprocessor did not accept leave every entry untouched.

When more than one result is ready, the lowest identifier wins. A result that has been offered stays offered, and stays stable, until the CPU takes it. Results can therefore leave in an order that differs from the issue order.

Top module: `spec_result_tracker`

## Requirements
- R1: After synchronous reset every entry is free and `res_valid` is 0.
- R2: An accepted instruction whose completion has arrived produces no result until a commit strobe with `cmt_kill`=0 has been seen for its identifier.
- R3: If the completion is already held, `res_valid` rises, with `res_id` equal to the committed identifier, in the same cycle as the clearing commit strobe.
- R4: A commit strobe (with either kill value) for an identifier whose issue was not accepted changes no state. A later completion report for that identifier produces no result, and the identifier can then be issued, accepted and completed normally.
- R5: A killed instruction never produces a result, whether the kill comes before, after or in the same cycle as its completion. Its identifier is free again for issue once the kill and the completion have both been seen.
- R6: Each accepted, committed, unkilled instruction produces exactly one result handshake, carrying the stored data, destination, write enables and exception/debug/error flags. The entry is free after that handshake.
- R7: Once `res_valid` is 1 without `res_ready`, the next cycle shows `res_valid`=1 with the same `res_id` and flags (and the same data while `res_we[0]` is 1), even if a lower identifier has become ready meanwhile.
- R8: When no result is held, the lowest ready identifier is presented.
- R9: `res_we` is 2'b00 whenever `res_exc` is 1. `res_we[1]` is 1 only when `res_we[0]` is 1; a reported enable of 2'b10 leaves as 2'b00.
- R10: When the commit strobe and the completion for the same identifier fall in the same cycle, a clearing commit makes the result visible in the next cycle (not the same one), and a kill frees the entry silently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_fire | input | 1 | Issue handshake took place this cycle |
| iss_accept | input | 1 | Coprocessor accepted the issued instruction |
| iss_id | input | ID_W | Identifier of the issued instruction |
| cmt_valid | input | 1 | Commit strobe, one cycle per issue transaction |
| cmt_id | input | ID_W | Identifier the commit strobe refers to |
| cmt_kill | input | 1 | 1 kills the instruction, 0 clears it to retire |
| done_valid | input | 1 | Datapath completion report valid |
| done_id | input | ID_W | Identifier of the completed instruction |
| done_data | input | 32 | Result data |
| done_rd | input | 5 | Destination register index |
| done_we | input | 2 | Requested write enables (bit 0 low word, bit 1 pair word) |
| done_exc | input | 1 | Synchronous exception raised |
| done_dbg | input | 1 | Debug entry requested |
| done_err | input | 1 | Error reported |
| res_ready | input | 1 | CPU accepts the presented result |
| res_valid | output | 1 | Result presented |
| res_id | output | ID_W | Identifier of the presented result |
| res_data | output | 32 | Result data |
| res_rd | output | 5 | Destination register index |
| res_we | output | 2 | Write enables after legalisation |
| res_exc | output | 1 | Exception flag |
| res_dbg | output | 1 | Debug flag |
| res_err | output | 1 | Error flag |

## Verification
There are two same-cycle collisions in this block. One is a commit strobe landing on an entry that already holds its completion, so the result is offered in the strobe's own cycle. The other is a commit strobe and a completion report hitting the same entry together. The bench walks every identifier through all six orderings of commit (clear or kill) against completion, including both collisions. It samples `res_valid` inside the strobe cycle and again after it, and compares against the cycle each requirement predicts. Every kill ordering is followed by a fresh issue of the same identifier, so an entry left occupied shows up as a missing result.

// File: rtl/trk_pkg.sv
package trk_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned RD_W   = 5;
    localparam int unsigned WE_W   = 2;

    typedef enum logic [2:0] {
        ST_FREE      = 3'd0,
        ST_SPEC      = 3'd1,
        ST_SPEC_DONE = 3'd2,
        ST_CMT       = 3'd3,
        ST_READY     = 3'd4,
        ST_KILLED    = 3'd5
    } ent_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [RD_W-1:0]   rd;
        logic [WE_W-1:0]   we;
        logic              exc;
        logic              dbg;
        logic              err;
    } res_pl_t;

    // An exception suppresses all writeback; the pair word only with the low word.
    function automatic logic [WE_W-1:0] legal_we(input logic [WE_W-1:0] we, input logic exc);
        logic [WE_W-1:0] r;
        r = exc ? '0 : {we[1] & we[0], we[0]};
        return r;
    endfunction

endpackage

// File: rtl/trk_entry.sv
module trk_entry
    import trk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    iss_hit,
    input  logic    cmt_hit,
    input  logic    cmt_kill,
    input  logic    done_hit,
    input  res_pl_t done_pl,
    input  logic    res_taken,
    output logic    elig_o,
    output res_pl_t pl_o
);

    ent_state_e st_q, st_d;
    res_pl_t    pl_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_FREE: begin
                if (iss_hit) st_d = ST_SPEC;
            end
            ST_SPEC: begin
                if (cmt_hit && cmt_kill)  st_d = done_hit ? ST_FREE  : ST_KILLED;
                else if (cmt_hit)         st_d = done_hit ? ST_READY : ST_CMT;
                else if (done_hit)        st_d = ST_SPEC_DONE;
            end
            ST_SPEC_DONE: begin
                if (cmt_hit) begin
                    if (cmt_kill)       st_d = ST_FREE;
                    else if (res_taken) st_d = ST_FREE;
                    else                st_d = ST_READY;
                end
            end
            ST_CMT: begin
                if (done_hit) st_d = ST_READY;
            end
            ST_READY: begin
                if (res_taken) st_d = ST_FREE;
            end
            ST_KILLED: begin
                if (done_hit) st_d = ST_FREE;
            end
            default: st_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_FREE;
            pl_q <= '0;
        end else begin
            st_q <= st_d;
            if (done_hit && (st_q == ST_SPEC || st_q == ST_CMT)) pl_q <= done_pl;
        end
    end

    // Ready entries, plus a held completion whose clearing commit arrives now.
    assign elig_o = (st_q == ST_READY) ||
                    (st_q == ST_SPEC_DONE && cmt_hit && !cmt_kill);
    assign pl_o   = pl_q;

    // R2: a handshake may only take an entry that is committed and complete
    assert_taken_only_eligible_R2: assert property (@(posedge clk) disable iff (rst)
        res_taken |-> elig_o);

    // R5: a killed entry never hands out a result
    assert_killed_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_KILLED) |-> !res_taken);

    // R6: after its one handshake the entry is free
    assert_single_result_R6: assert property (@(posedge clk) disable iff (rst)
        res_taken |=> (st_q == ST_FREE));

    // R6: identifiers are only claimed while free
    assert_claim_free_only_R6: assert property (@(posedge clk) disable iff (rst)
        iss_hit |-> (st_q == ST_FREE));

endmodule

// File: rtl/trk_picker.sv
module trk_picker #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     elig,
    input  logic             res_ready,
    output logic             res_valid,
    output logic [IDX_W-1:0] sel
);

    logic             lock_q;
    logic [IDX_W-1:0] lock_id_q;
    logic [IDX_W-1:0] low;

    // Fixed priority: lowest index wins.
    always_comb begin
        low = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) low = IDX_W'(i);
        end
    end

    assign sel       = lock_q ? lock_id_q : low;
    assign res_valid = lock_q || (|elig);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q    <= 1'b0;
            lock_id_q <= '0;
        end else begin
            lock_q    <= res_valid && !res_ready;
            lock_id_q <= sel;
        end
    end

    // R7: a held selection always points at an entry that is still ready
    assert_lock_target_ready_R7: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> elig[lock_id_q]);

    // R7: an unaccepted offer persists with the same selection
    assert_hold_until_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && sel == $past(sel)));

endmodule

// File: rtl/spec_result_tracker.sv
module spec_result_tracker
    import trk_pkg::*;
#(
    parameter int unsigned ID_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_fire,
    input  logic              iss_accept,
    input  logic [ID_W-1:0]   iss_id,
    input  logic              cmt_valid,
    input  logic [ID_W-1:0]   cmt_id,
    input  logic              cmt_kill,
    input  logic              done_valid,
    input  logic [ID_W-1:0]   done_id,
    input  logic [DATA_W-1:0] done_data,
    input  logic [RD_W-1:0]   done_rd,
    input  logic [WE_W-1:0]   done_we,
    input  logic              done_exc,
    input  logic              done_dbg,
    input  logic              done_err,
    input  logic              res_ready,
    output logic              res_valid,
    output logic [ID_W-1:0]   res_id,
    output logic [DATA_W-1:0] res_data,
    output logic [RD_W-1:0]   res_rd,
    output logic [WE_W-1:0]   res_we,
    output logic              res_exc,
    output logic              res_dbg,
    output logic              res_err
);

    localparam int unsigned N = 1 << ID_W;

    res_pl_t          done_pl;
    res_pl_t          ent_pl [N];
    res_pl_t          out_pl;
    logic [N-1:0]     elig;
    logic [ID_W-1:0]  sel;

    assign done_pl = '{data: done_data, rd: done_rd, we: done_we,
                       exc: done_exc, dbg: done_dbg, err: done_err};

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic iss_hit_w, cmt_hit_w, done_hit_w, taken_w;
        assign iss_hit_w  = iss_fire && iss_accept && (iss_id == ID_W'(g));
        assign cmt_hit_w  = cmt_valid && (cmt_id == ID_W'(g));
        assign done_hit_w = done_valid && (done_id == ID_W'(g));
        assign taken_w    = res_valid && res_ready && (sel == ID_W'(g));

        trk_entry u_entry (
            .clk       (clk),
            .rst       (rst),
            .iss_hit   (iss_hit_w),
            .cmt_hit   (cmt_hit_w),
            .cmt_kill  (cmt_kill),
            .done_hit  (done_hit_w),
            .done_pl   (done_pl),
            .res_taken (taken_w),
            .elig_o    (elig[g]),
            .pl_o      (ent_pl[g])
        );
    end

    trk_picker #(.N(N), .IDX_W(ID_W)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .res_ready (res_ready),
        .res_valid (res_valid),
        .sel       (sel)
    );

    assign out_pl   = ent_pl[sel];
    assign res_id   = sel;
    assign res_data = out_pl.data;
    assign res_rd   = out_pl.rd;
    assign res_we   = legal_we(out_pl.we, out_pl.exc);
    assign res_exc  = out_pl.exc;
    assign res_dbg  = out_pl.dbg;
    assign res_err  = out_pl.err;

    // R9: no writeback alongside an exception
    assert_we_clear_on_exc_R9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_exc) |-> (res_we == '0));

    // R9: the pair enable never appears alone
    assert_we_pair_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !(res_we[1] && !res_we[0]));

    // R7: the offered packet holds steady while it waits
    assert_packet_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_id) && $stable(res_we) && $stable(res_exc) &&
             $stable(res_dbg) && $stable(res_err) && $stable(res_rd) &&
             (!res_we[0] || $stable(res_data))));

endmodule

// File: tb/tb_spec_result_tracker.sv
`timescale 1ns/1ps
module tb_spec_result_tracker;

    localparam int ID_W = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            iss_fire = 0, iss_accept = 0;
    logic [ID_W-1:0] iss_id = '0;
    logic            cmt_valid = 0, cmt_kill = 0;
    logic [ID_W-1:0] cmt_id = '0;
    logic            done_valid = 0;
    logic [ID_W-1:0] done_id = '0;
    logic [31:0]     done_data = '0;
    logic [4:0]      done_rd = '0;
    logic [1:0]      done_we = '0;
    logic            done_exc = 0, done_dbg = 0, done_err = 0;
    logic            res_ready = 0;
    logic            res_valid;
    logic [ID_W-1:0] res_id;
    logic [31:0]     res_data;
    logic [4:0]      res_rd;
    logic [1:0]      res_we;
    logic            res_exc, res_dbg, res_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    spec_result_tracker #(.ID_W(ID_W)) dut (
        .clk(clk), .rst(rst),
        .iss_fire(iss_fire), .iss_accept(iss_accept), .iss_id(iss_id),
        .cmt_valid(cmt_valid), .cmt_id(cmt_id), .cmt_kill(cmt_kill),
        .done_valid(done_valid), .done_id(done_id), .done_data(done_data),
        .done_rd(done_rd), .done_we(done_we), .done_exc(done_exc),
        .done_dbg(done_dbg), .done_err(done_err),
        .res_ready(res_ready), .res_valid(res_valid), .res_id(res_id),
        .res_data(res_data), .res_rd(res_rd), .res_we(res_we),
        .res_exc(res_exc), .res_dbg(res_dbg), .res_err(res_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        iss_fire = 0; iss_accept = 0; cmt_valid = 0; cmt_kill = 0;
        done_valid = 0; res_ready = 0;
        #1;
    endtask

    task automatic do_issue(input logic [ID_W-1:0] id, input logic acc);
        iss_fire = 1; iss_accept = acc; iss_id = id;
        tick();
    endtask

    task automatic set_done(input logic [ID_W-1:0] id, input logic [31:0] d, input logic [4:0] rd,
                            input logic [1:0] we, input logic exc, input logic dbg, input logic err);
        done_valid = 1; done_id = id; done_data = d; done_rd = rd;
        done_we = we; done_exc = exc; done_dbg = dbg; done_err = err;
    endtask

    task automatic set_cmt(input logic [ID_W-1:0] id, input logic kill);
        cmt_valid = 1; cmt_id = id; cmt_kill = kill;
    endtask

    task automatic take_result(input logic [ID_W-1:0] id, input logic [31:0] d, input logic [4:0] rd,
                               input logic [1:0] we, input logic exc, input logic dbg, input logic err,
                               input logic more, input logic [ID_W-1:0] nxt, input string tag);
        check({tag, " R6 valid"}, 64'(res_valid), 64'd1);
        check({tag, " R6 id"},    64'(res_id),    64'(id));
        check({tag, " R6 data"},  64'(res_data),  64'(d));
        check({tag, " R6 rd"},    64'(res_rd),    64'(rd));
        check({tag, " R9 we"},    64'(res_we),    64'(we));
        check({tag, " R6 flags"}, 64'({res_exc, res_dbg, res_err}), 64'({exc, dbg, err}));
        res_ready = 1;
        tick();
        check({tag, " R6 after handshake"}, 64'(res_valid), 64'(more));
        if (more) check({tag, " R8 next lowest"}, 64'(res_id), 64'(nxt));
    endtask

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        check("R1 reset valid", 64'(res_valid), 64'd0);
        tick();
        check("R1 idle valid", 64'(res_valid), 64'd0);

        // Sweep every identifier through every commit/completion ordering.
        for (int id = 0; id < 8; id++) begin
            for (int sc = 0; sc < 6; sc++) begin
                logic        kill;
                int          order;
                logic [31:0] d;
                logic [4:0]  rd;
                logic [ID_W-1:0] i3;
                i3    = ID_W'(id);
                kill  = sc[0];
                order = sc / 2;
                d     = 32'hC000_0000 | 32'(id << 8) | 32'(sc);
                rd    = 5'(id * 3 + sc + 1);
                do_issue(i3, 1'b1);
                check("R2 after issue", 64'(res_valid), 64'd0);
                if (order == 0) begin
                    set_done(i3, d, rd, 2'b01, 1'b0, i3[0], i3[1]);
                    tick();
                    check("R2 done uncommitted", 64'(res_valid), 64'd0);
                    set_cmt(i3, kill);
                    #1;
                    if (kill) check("R5 kill after done", 64'(res_valid), 64'd0);
                    else begin
                        check("R3 same-cycle valid", 64'(res_valid), 64'd1);
                        check("R3 same-cycle id", 64'(res_id), 64'(i3));
                    end
                    tick();
                end else if (order == 1) begin
                    set_cmt(i3, kill);
                    tick();
                    check("R2 committed not done", 64'(res_valid), 64'd0);
                    set_done(i3, d, rd, 2'b01, 1'b0, i3[0], i3[1]);
                    tick();
                end else begin
                    set_done(i3, d, rd, 2'b01, 1'b0, i3[0], i3[1]);
                    set_cmt(i3, kill);
                    #1;
                    check("R10 collide cycle", 64'(res_valid), 64'd0);
                    tick();
                end
                if (!kill) begin
                    take_result(i3, d, rd, 2'b01, 1'b0, i3[0], i3[1], 1'b0, '0, "sweep");
                end else begin
                    check("R5 killed silent", 64'(res_valid), 64'd0);
                    tick();
                    check("R5 killed silent later", 64'(res_valid), 64'd0);
                end
            end
        end

        // Write-enable legalisation over all enable/exception combinations.
        for (int k = 0; k < 8; k++) begin
            logic [1:0] we;
            logic       exc;
            logic [1:0] exp_we;
            we     = 2'(k);
            exc    = k[2];
            exp_we = exc ? 2'b00 : ((we == 2'b10) ? 2'b00 : we);
            do_issue(ID_W'(k), 1'b1);
            set_cmt(ID_W'(k), 1'b0);
            tick();
            set_done(ID_W'(k), 32'h5A00 + 32'(k), 5'(k), we, exc, 1'b0, 1'b1);
            tick();
            take_result(ID_W'(k), 32'h5A00 + 32'(k), 5'(k), exp_we, exc, 1'b0, 1'b1, 1'b0, '0, "R9 sweep");
        end

        // Commit strobes for rejected issues are ignored.
        for (int kv = 0; kv < 2; kv++) begin
            do_issue(3'd3, 1'b0);
            set_cmt(3'd3, kv[0]);
            tick();
            check("R4 rejected commit", 64'(res_valid), 64'd0);
            set_done(3'd3, 32'hDEAD_0000, 5'd9, 2'b01, 1'b0, 1'b0, 1'b0);
            tick();
            check("R4 stray completion", 64'(res_valid), 64'd0);
            tick();
            check("R4 stray completion later", 64'(res_valid), 64'd0);
        end
        do_issue(3'd3, 1'b1);
        set_done(3'd3, 32'h0BEE_F003, 5'd17, 2'b11, 1'b0, 1'b1, 1'b0);
        tick();
        set_cmt(3'd3, 1'b0);
        tick();
        take_result(3'd3, 32'h0BEE_F003, 5'd17, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R4 reuse");

        // Hold and lowest-first ordering.
        do_issue(3'd5, 1'b1);
        do_issue(3'd2, 1'b1);
        do_issue(3'd6, 1'b1);
        set_done(3'd5, 32'h55, 5'd5, 2'b01, 1'b0, 1'b0, 1'b0); tick();
        set_done(3'd2, 32'h22, 5'd2, 2'b01, 1'b0, 1'b0, 1'b0); tick();
        set_done(3'd6, 32'h66, 5'd6, 2'b01, 1'b0, 1'b0, 1'b0); tick();
        check("R2 three done none committed", 64'(res_valid), 64'd0);
        set_cmt(3'd6, 1'b0);
        #1;
        check("R3 commit six valid", 64'(res_valid), 64'd1);
        check("R3 commit six id", 64'(res_id), 64'd6);
        tick();
        check("R7 six held", 64'(res_id), 64'd6);
        set_cmt(3'd2, 1'b0);
        tick();
        check("R7 held over two", 64'(res_id), 64'd6);
        check("R7 held valid", 64'(res_valid), 64'd1);
        set_cmt(3'd5, 1'b0);
        tick();
        check("R7 held over five", 64'(res_id), 64'd6);
        check("R7 held data", 64'(res_data), 64'h66);
        take_result(3'd6, 32'h66, 5'd6, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, "R8 order six");
        take_result(3'd2, 32'h22, 5'd2, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, "R8 order two");
        take_result(3'd5, 32'h55, 5'd5, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8 order five");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule